// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Logic

This block is the processor-facing side of a classic single-byte-buffered serial port. It decodes bus accesses into eight byte registers: receive/transmit data, interrupt enables, interrupt identification, line control, modem control, line status, modem status and a scratch byte. A divisor latch is reached through the same two low offsets while the access bit in line control is set. The serial bit engine sits outside the block. This block hands it a one-cycle transmit strobe with the byte, accepts received bytes and break events, and presents the decoded framing, the baud rate and the break level.

The bus offset comes from a memory-mapped decode by default. The address minus a base is shifted right by a stride, and only addresses inside a window of `8 << STRIDE` bytes respond. A parameter selects a plain 3-bit decode instead. The interrupt output is a level. It is derived from the enables, the data-ready bit and a hidden transmit-empty pending flag. That flag is separate from the line status: reading the identification register clears it, and rewriting the enables re-arms it.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x01, modem status (offset 6) reads 0xB0, line control reads 0x00, and `irq` and `txStrobe` are low.
- R2: The register offset is bits [STRIDE+2:STRIDE] of (addr − BASE). An access with addr below BASE, or at or beyond BASE + (8 << STRIDE), writes nothing and reads 0x00.
- R3: While line-control bit 7 is 1, offset 0 accesses divisor bits 7:0 and offset 1 accesses divisor bits 15:8, leaving the data and enable registers untouched.
- R4: An enable write keeps bits 3:0 only, and a modem-control write keeps bits 4:0 only. Writes to offsets 5 and 6 change nothing. Offset 7 reads back what was written.
- R5: A data write (offset 0, bit 7 of line control clear) raises `txStrobe` for exactly the next cycle with `txByte` equal to the written byte. Afterwards line status has bit 5 (holding empty) and bit 6 (shifter empty) set, and the transmit-empty pending flag is set.
- R6: An enable write while line-status bit 5 is set re-arms the transmit-empty pending flag.
- R7: A received byte is loaded and line-status bit 0 (data ready) is set only while bit 0 is clear. Otherwise the byte is dropped. A break loads 0x00 and sets bits 4 and 0.
- R8: Reading offset 0 with bit 7 of line control clear returns the held byte and clears line-status bits 0 and 4.
- R9: Identification reads 0x04 when enable bit 0 and data ready are both set. Otherwise it reads 0x02 when enable bit 1 and the pending flag are both set. Otherwise it reads 0x01. `irq` is high exactly when the value is not 0x01.
- R10: A read of offset 2 that returns 0x02 clears the pending flag, so the next read returns 0x01 when nothing else is pending.
- R11: Framing outputs follow line control: data bits = bits[1:0] + 5, two stop bits when bit 2 is set, parity enabled by bit 3, even parity when bit 4 is set.
- R12: `paramUpdate` pulses for one cycle after a write to line control or either divisor byte, only if the resulting divisor is nonzero. `baudRate` is 115200 / divisor, or 0 when the divisor is 0.
- R13: `breakEn` follows line-control bit 6. `breakChange` pulses for one cycle after a line-control write only when bit 6 differs from the previously applied value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access select |
| wrEn | input | 1 | Write access |
| rdEn | input | 1 | Read access (side effects at the clock edge) |
| addr | input | ADDR_W | Bus byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from the addressed register |
| irq | output | 1 | Level interrupt request |
| txStrobe | output | 1 | One-cycle transmit byte strobe |
| txByte | output | 8 | Byte to transmit |
| rxValid | input | 1 | Received byte present |
| rxByte | input | 8 | Received byte |
| rxBreak | input | 1 | Break condition received |
| rxReady | output | 1 | Receive holding register can accept a byte |
| breakEn | output | 1 | Break level to drive on the line |
| breakChange | output | 1 | One-cycle pulse when the break level changed |
| paramUpdate | output | 1 | One-cycle pulse when framing or rate was rewritten with a valid divisor |
| dataBits | output | 4 | Data bits per character (5..8) |
| twoStop | output | 1 | Two stop bits selected |
| parityEn | output | 1 | Parity enabled |
| parityEven | output | 1 | Even parity selected |
| baudRate | output | 32 | Rate derived from the divisor, 0 when the divisor is 0 |

## Verification
A stale pending flag is the subtle failure. It shows as an identification value of 0x02 that survives its own read, or as `irq` staying high after a read should have dropped it. Both are visible on the next access. A wrong data-ready bit shows one access later, either as a dropped byte that overwrites the held one or as a line-status read with bit 0 in the wrong state. Break and rate pulses are one-cycle events, so a missing or spurious one is visible in the cycle right after the line-control or divisor write.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrThr;
    logic wrIer;
    logic wrLcr;
    logic wrMcr;
    logic wrScr;
    logic wrDll;
    logic wrDlm;
    logic rdRbr;
    logic rdIirClr;
  } regStrobes_t;

  localparam int unsigned OFF_W = 3;

  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_THRE = 8'h02;
  localparam logic [7:0] IIR_RDA  = 8'h04;
  localparam logic [7:0] LSR_INIT = 8'h60;
  localparam logic [7:0] MSR_INIT = 8'hB0;

  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_BI   = 4;
  localparam int unsigned LSR_THRE = 5;
  localparam int unsigned LSR_TEMT = 6;
  localparam int unsigned LCR_DLAB = 7;
  localparam int unsigned LCR_BRK  = 6;

endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter bit          USE_MMIO = 1'b1,
  parameter int unsigned BASE     = 'h100,
  parameter int unsigned STRIDE   = 2
) (
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  input  logic [7:0]        iirVal,
  output logic [OFF_W-1:0]  offset,
  output logic              hit,
  output regStrobes_t       strb
);

  generate
    if (USE_MMIO) begin : g_mmio
      localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
      logic [ADDR_W-1:0] relAddr;
      assign relAddr = addr - BASE_A;
      assign hit     = (addr >= BASE_A) && ((relAddr >> (STRIDE + OFF_W)) == '0);
      assign offset  = relAddr[STRIDE +: OFF_W];
    end else begin : g_plain
      assign hit    = 1'b1;
      assign offset = addr[OFF_W-1:0];
    end
  endgenerate

  logic access;
  assign access = sel && hit;

  always_comb begin
    strb = '0;
    if (access && wrEn) begin
      case (offset)
        3'd0: if (dlab) strb.wrDll = 1'b1; else strb.wrThr = 1'b1;
        3'd1: if (dlab) strb.wrDlm = 1'b1; else strb.wrIer = 1'b1;
        3'd3: strb.wrLcr = 1'b1;
        3'd4: strb.wrMcr = 1'b1;
        3'd7: strb.wrScr = 1'b1;
        default: ;
      endcase
    end
    if (access && rdEn) begin
      if (offset == 3'd0 && !dlab) strb.rdRbr = 1'b1;
      if (offset == 3'd2 && iirVal == IIR_THRE) strb.rdIirClr = 1'b1;
    end
  end

endmodule

// File: rtl/uart_reg_dpath.sv
module uart_reg_dpath
  import uart_regs_pkg::*;
#(
  parameter int unsigned REF_BAUD = 115200
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strb,
  input  logic [OFF_W-1:0] offset,
  input  logic [7:0]       wrData,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxBreak,
  output logic [7:0]       rdValue,
  output logic             dlab,
  output logic [7:0]       iirVal,
  output logic             irq,
  output logic             txStrobe,
  output logic [7:0]       txByte,
  output logic             rxReady,
  output logic             breakEn,
  output logic             breakChange,
  output logic             paramUpdate,
  output logic [3:0]       dataBits,
  output logic             twoStop,
  output logic             parityEn,
  output logic             parityEven,
  output logic [31:0]      baudRate,
  output logic [7:0]       lsrQ,
  output logic [3:0]       ierQ,
  output logic             thrPending,
  output logic [7:0]       rbrQ,
  output logic [15:0]      divisorQ
);

  logic [7:0]  lcrQ;
  logic [4:0]  mcrQ;
  logic [7:0]  scrQ;
  logic [15:0] divNext;

  always_comb begin
    divNext = divisorQ;
    if (strb.wrDll) divNext[7:0]  = wrData;
    if (strb.wrDlm) divNext[15:8] = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrQ        <= '0;
      mcrQ        <= '0;
      scrQ        <= '0;
      ierQ        <= '0;
      rbrQ        <= '0;
      divisorQ    <= '0;
      lsrQ        <= LSR_INIT;
      thrPending  <= 1'b0;
      txStrobe    <= 1'b0;
      txByte      <= '0;
      breakEn     <= 1'b0;
      breakChange <= 1'b0;
      paramUpdate <= 1'b0;
    end else begin
      divisorQ    <= divNext;
      txStrobe    <= strb.wrThr;
      breakChange <= strb.wrLcr && (wrData[LCR_BRK] != breakEn);
      paramUpdate <= (strb.wrLcr || strb.wrDll || strb.wrDlm) && (divNext != 16'd0);
      if (strb.wrLcr) begin
        lcrQ    <= wrData;
        breakEn <= wrData[LCR_BRK];
      end
      if (strb.wrMcr) mcrQ <= wrData[4:0];
      if (strb.wrScr) scrQ <= wrData;
      if (strb.wrIer) ierQ <= wrData[3:0];
      if (strb.wrThr) begin
        txByte         <= wrData;
        lsrQ[LSR_THRE] <= 1'b1;
        lsrQ[LSR_TEMT] <= 1'b1;
      end
      // Pending flag: transmit write and enable re-arm beat an identification read
      if (strb.wrThr || (strb.wrIer && lsrQ[LSR_THRE])) thrPending <= 1'b1;
      else if (strb.rdIirClr)                           thrPending <= 1'b0;
      // Receive side: a read clears, an arriving event in the same cycle wins
      if (strb.rdRbr) begin
        lsrQ[LSR_DR] <= 1'b0;
        lsrQ[LSR_BI] <= 1'b0;
      end
      if (rxBreak) begin
        rbrQ         <= 8'h00;
        lsrQ[LSR_DR] <= 1'b1;
        lsrQ[LSR_BI] <= 1'b1;
      end else if (rxValid && !lsrQ[LSR_DR]) begin
        rbrQ         <= rxByte;
        lsrQ[LSR_DR] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (ierQ[0] && lsrQ[LSR_DR])   iirVal = IIR_RDA;
    else if (ierQ[1] && thrPending) iirVal = IIR_THRE;
    else                            iirVal = IIR_NONE;
  end

  assign irq     = (iirVal != IIR_NONE);
  assign dlab    = lcrQ[LCR_DLAB];
  assign rxReady = !lsrQ[LSR_DR];

  assign dataBits   = {2'b00, lcrQ[1:0]} + 4'd5;
  assign twoStop    = lcrQ[2];
  assign parityEn   = lcrQ[3];
  assign parityEven = lcrQ[4];

  logic [31:0] baudQuot;
  assign baudQuot = (divisorQ == 16'd0) ? 32'd0 : (32'(REF_BAUD) / {16'd0, divisorQ});
  assign baudRate = baudQuot;

  always_comb begin
    case (offset)
      3'd0:    rdValue = dlab ? divisorQ[7:0]  : rbrQ;
      3'd1:    rdValue = dlab ? divisorQ[15:8] : {4'd0, ierQ};
      3'd2:    rdValue = iirVal;
      3'd3:    rdValue = lcrQ;
      3'd4:    rdValue = {3'd0, mcrQ};
      3'd5:    rdValue = lsrQ;
      3'd6:    rdValue = MSR_INIT;
      default: rdValue = scrQ;
    endcase
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter bit          USE_MMIO = 1'b1,
  parameter int unsigned BASE     = 'h100,
  parameter int unsigned STRIDE   = 2,
  parameter int unsigned REF_BAUD = 115200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq,
  output logic              txStrobe,
  output logic [7:0]        txByte,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxBreak,
  output logic              rxReady,
  output logic              breakEn,
  output logic              breakChange,
  output logic              paramUpdate,
  output logic [3:0]        dataBits,
  output logic              twoStop,
  output logic              parityEn,
  output logic              parityEven,
  output logic [31:0]       baudRate
);

  regStrobes_t      strb;
  logic [OFF_W-1:0] offset;
  logic             hit;
  logic             dlab;
  logic [7:0]       iirVal;
  logic [7:0]       rdValue;
  logic [7:0]       lsrW;
  logic [3:0]       ierW;
  logic             pendW;
  logic [7:0]       rbrW;
  logic [15:0]      divW;

  uart_reg_ctrl #(
    .ADDR_W(ADDR_W), .USE_MMIO(USE_MMIO), .BASE(BASE), .STRIDE(STRIDE)
  ) u_ctrl (
    .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .dlab(dlab),
    .iirVal(iirVal), .offset(offset), .hit(hit), .strb(strb)
  );

  uart_reg_dpath #(.REF_BAUD(REF_BAUD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .offset(offset), .wrData(wrData),
    .rxValid(rxValid), .rxByte(rxByte), .rxBreak(rxBreak),
    .rdValue(rdValue), .dlab(dlab), .iirVal(iirVal), .irq(irq),
    .txStrobe(txStrobe), .txByte(txByte), .rxReady(rxReady),
    .breakEn(breakEn), .breakChange(breakChange), .paramUpdate(paramUpdate),
    .dataBits(dataBits), .twoStop(twoStop), .parityEn(parityEn),
    .parityEven(parityEven), .baudRate(baudRate),
    .lsrQ(lsrW), .ierQ(ierW), .thrPending(pendW), .rbrQ(rbrW), .divisorQ(divW)
  );

  assign rdData = hit ? rdValue : 8'h00;

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic        txStrobe,
  input logic        irq,
  input logic        rxValid,
  input logic        rxBreak,
  input logic        breakChange,
  input logic        breakEn,
  input logic        paramUpdate,
  input logic [7:0]  lsr,
  input logic [3:0]  ier,
  input logic        pend,
  input logic [7:0]  rbr,
  input logic [15:0] divisor
);

  p_tx_thre_r5: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> (lsr[5] && lsr[6]));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((ier[0] && lsr[0]) || (ier[1] && pend)));

  p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxBreak && lsr[0]) |=> (rbr == $past(rbr)));

  p_break_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxBreak |=> (rbr == 8'h00 && lsr[4] && lsr[0]));

  p_brk_edge_r13: assert property (@(posedge clk) disable iff (!rstN)
    breakChange |-> !$stable(breakEn));

  p_param_nonzero_r12: assert property (@(posedge clk) disable iff (!rstN)
    paramUpdate |-> (divisor != 16'd0));

endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rstN(rstN), .txStrobe(txStrobe), .irq(irq),
  .rxValid(rxValid), .rxBreak(rxBreak), .breakChange(breakChange),
  .breakEn(breakEn), .paramUpdate(paramUpdate),
  .lsr(lsrW), .ier(ierW), .pend(pendW), .rbr(rbrW), .divisor(divW)
);

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BASE   = 'h100;
  localparam int unsigned STRIDE = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wrData = '0;
  logic [7:0]        rdData;
  logic              irq, txStrobe, rxReady, breakEn, breakChange, paramUpdate;
  logic [7:0]        txByte;
  logic              rxValid = 1'b0, rxBreak = 1'b0;
  logic [7:0]        rxByte = '0;
  logic [3:0]        dataBits;
  logic              twoStop, parityEn, parityEven;
  logic [31:0]       baudRate;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  uart_regfile #(.ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)) i_uart_regfile (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txStrobe(txStrobe),
    .txByte(txByte), .rxValid(rxValid), .rxByte(rxByte), .rxBreak(rxBreak),
    .rxReady(rxReady), .breakEn(breakEn), .breakChange(breakChange),
    .paramUpdate(paramUpdate), .dataBits(dataBits), .twoStop(twoStop),
    .parityEn(parityEn), .parityEven(parityEven), .baudRate(baudRate)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busRaw(input logic isWr, input logic [ADDR_W-1:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    sel = 1'b1; wrEn = isWr; rdEn = !isWr; addr = a; wrData = d;
    #1 q = rdData;
    @(posedge clk);
    #1 sel = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] regAddr(input logic [2:0] off);
    return ADDR_W'(BASE) + (ADDR_W'(off) << STRIDE);
  endfunction

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    logic [7:0] q;
    busRaw(1'b1, regAddr(off), d, q);
  endtask

  task automatic rdChk(input string tag, input logic [2:0] off, input logic [7:0] exp);
    logic [7:0] q;
    busRaw(1'b0, regAddr(off), 8'h00, q);
    check(tag, {24'd0, q}, {24'd0, exp});
  endtask

  task automatic rxPulse(input logic brk, input logic [7:0] b);
    @(negedge clk);
    rxValid = !brk; rxBreak = brk; rxByte = b;
    @(posedge clk);
    #1 rxValid = 1'b0; rxBreak = 1'b0;
  endtask

  // {write, offset[2:0], data-or-expected[7:0], requirement number[7:0]}
  localparam int NVEC = 24;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 3'd5, 8'h60, 8'd1},   // R1 line status reset
    {1'b0, 3'd2, 8'h01, 8'd1},   // R1 identification reset
    {1'b0, 3'd6, 8'hB0, 8'd1},   // R1 modem status reset
    {1'b0, 3'd3, 8'h00, 8'd1},   // R1 line control reset
    {1'b1, 3'd7, 8'hA5, 8'd4},   // R4 scratch write
    {1'b0, 3'd7, 8'hA5, 8'd4},   // R4 scratch readback
    {1'b1, 3'd4, 8'hFF, 8'd4},   // R4 modem control write
    {1'b0, 3'd4, 8'h1F, 8'd4},   // R4 masked to 4:0
    {1'b1, 3'd5, 8'h00, 8'd4},   // R4 line status write ignored
    {1'b0, 3'd5, 8'h60, 8'd4},
    {1'b1, 3'd6, 8'h00, 8'd4},   // R4 modem status write ignored
    {1'b0, 3'd6, 8'hB0, 8'd4},
    {1'b1, 3'd1, 8'hFF, 8'd6},   // R6 enables written while holding empty
    {1'b0, 3'd1, 8'h0F, 8'd4},   // R4 masked to 3:0
    {1'b0, 3'd2, 8'h02, 8'd6},   // R6 re-armed pending reported
    {1'b0, 3'd2, 8'h01, 8'd10},  // R10 previous read cleared it
    {1'b1, 3'd3, 8'h83, 8'd3},   // R3 open divisor latch
    {1'b1, 3'd0, 8'h34, 8'd3},
    {1'b1, 3'd1, 8'h12, 8'd3},
    {1'b0, 3'd0, 8'h34, 8'd3},   // R3 divisor low
    {1'b0, 3'd1, 8'h12, 8'd3},   // R3 divisor high
    {1'b1, 3'd3, 8'h03, 8'd3},   // R3 close latch
    {1'b0, 3'd3, 8'h03, 8'd3},
    {1'b0, 3'd1, 8'h0F, 8'd3}    // R3 enables untouched by divisor writes
  };

  initial begin
    #(20 * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 txStrobe", {31'd0, txStrobe}, 32'd0);
    check("R1 breakEn", {31'd0, breakEn}, 32'd0);
    check("R7 rxReady", {31'd0, rxReady}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else rdChk($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][18:16], VEC[i][15:8]);
    end

    // R5 transmit
    wr(3'd0, 8'h5A);
    check("R5 txStrobe", {31'd0, txStrobe}, 32'd1);
    check("R5 txByte", {24'd0, txByte}, 32'h5A);
    check("R9 irq tx", {31'd0, irq}, 32'd1);
    rdChk("R5 lsr", 3'd5, 8'h60);
    check("R5 strobe single", {31'd0, txStrobe}, 32'd0);
    rdChk("R9 iir tx", 3'd2, 8'h02);
    rdChk("R10 iir cleared", 3'd2, 8'h01);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    // R7 / R8 receive
    rxPulse(1'b0, 8'h3C);
    rdChk("R7 lsr dr", 3'd5, 8'h61);
    check("R7 rxReady", {31'd0, rxReady}, 32'd0);
    rdChk("R9 iir rx", 3'd2, 8'h04);
    rxPulse(1'b0, 8'h77);
    rdChk("R7 drop keeps byte", 3'd0, 8'h3C);
    rdChk("R8 lsr cleared", 3'd5, 8'h60);
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R9 priority with both sources
    wr(3'd1, 8'h0F);
    rxPulse(1'b0, 8'h11);
    rdChk("R9 rx first", 3'd2, 8'h04);
    rdChk("R8 rbr", 3'd0, 8'h11);
    rdChk("R9 tx next", 3'd2, 8'h02);
    rdChk("R10 none", 3'd2, 8'h01);

    // R7 break
    rxPulse(1'b1, 8'hFF);
    rdChk("R7 break lsr", 3'd5, 8'h71);
    rdChk("R7 break byte", 3'd0, 8'h00);
    rdChk("R8 break cleared", 3'd5, 8'h60);

    // R11 / R12 / R13 framing, rate, break level
    wr(3'd3, 8'h1F);
    check("R11 dataBits", {28'd0, dataBits}, 32'd8);
    check("R11 twoStop", {31'd0, twoStop}, 32'd1);
    check("R11 parityEn", {31'd0, parityEn}, 32'd1);
    check("R11 parityEven", {31'd0, parityEven}, 32'd1);
    check("R12 paramUpdate lcr", {31'd0, paramUpdate}, 32'd1);
    check("R12 baud", baudRate, 32'd24);
    check("R13 no change", {31'd0, breakChange}, 32'd0);
    wr(3'd3, 8'h40);
    check("R13 change on", {31'd0, breakChange}, 32'd1);
    check("R13 breakEn", {31'd0, breakEn}, 32'd1);
    check("R11 dataBits 5", {28'd0, dataBits}, 32'd5);
    check("R11 parity off", {31'd0, parityEn}, 32'd0);
    wr(3'd3, 8'h41);
    check("R13 same level", {31'd0, breakChange}, 32'd0);
    wr(3'd3, 8'h80);
    check("R13 change off", {31'd0, breakChange}, 32'd1);
    check("R13 breakEn off", {31'd0, breakEn}, 32'd0);
    wr(3'd0, 8'h00);
    check("R12 update 0x1200", {31'd0, paramUpdate}, 32'd1);
    wr(3'd1, 8'h00);
    check("R12 zero divisor", {31'd0, paramUpdate}, 32'd0);
    check("R12 baud zero", baudRate, 32'd0);
    wr(3'd0, 8'h03);
    check("R12 update 3", {31'd0, paramUpdate}, 32'd1);
    check("R12 baud 38400", baudRate, 32'd38400);
    wr(3'd3, 8'h03);

    // R2 window decode
    busRaw(1'b1, ADDR_W'(BASE) + ADDR_W'(8 << STRIDE) + ADDR_W'(7 << STRIDE), 8'h33, q);
    rdChk("R2 outside write ignored", 3'd7, 8'hA5);
    busRaw(1'b0, ADDR_W'(BASE) - ADDR_W'(4), 8'h00, q);
    check("R2 below base reads zero", {24'd0, q}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule